// File: doc/BRIEF.md
# Dual-Path Total Overcurrent Detector

This block protects a multiphase supply against too much total output current. Each cycle in which the sample strobe is high, it takes one signed current sample per phase. It drops the phases whose enable bit is low and adds the rest into a single total. That total goes to two detection paths that do not interact.

Each path smooths the total with a first-order exponential moving average. The coefficient of that average is a programmable right shift. The path then compares the smoothed value with its own threshold. It sets its trip flag only after the value has stayed above the threshold for a programmed number of consecutive samples.

Path 0 is meant to run with a light filter and a short dwell, so it catches brief high peaks. Path 1 is meant to run with a heavy filter and a long dwell, so it catches lower overloads that last. A trip flag stays set until the control logic clears it. The combined fault output is high while either flag is set.

Top module: `tocp_top`

## Requirements
- R1: The total is the signed sum of the samples of the enabled phases. Phase p occupies bits [p*SW +: SW] of the sample bus. A phase whose enable bit is 0 adds zero, whatever its sample value.
- R2: When a path receives a total x, its filtered value f becomes f + ((x - f) >>> k). Here k is the path's 3-bit shift, from 0 to 7, and the shift is arithmetic and rounds toward minus infinity. With k = 0 the filtered value equals the total.
- R3: Neither the sum nor the filter wraps. Seven enabled full-scale samples, positive or negative, give their exact total.
- R4: A filtered value above the threshold (signed compare) adds one to the path's run count. The path trips when the count reaches its dwell setting, and a dwell of 0 acts as 1. The trip flag is visible two clock edges after the strobed sample.
- R5: A filtered value at or below the threshold resets the run count to zero.
- R6: A trip flag stays set until its clear bit is high. Clear bit i clears flag i. When a new trip and a clear arrive in the same cycle, the trip wins.
- R7: The combined fault output is the OR of the two trip flags.
- R8: Each path uses only its own shift, threshold, dwell and clear bit. Path i takes field i of each packed setting port: bits [i*3 +: 3], [i*SUMW +: SUMW] and [i*CW +: CW].
- R9: With the strobe low, the sample and enable inputs are ignored. Filtered values, run counts and flags do not change.
- R10: After reset, both filtered values are 0, both flags are 0 and the fault is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_vld | input | 1 | Sample strobe |
| smp_i | input | NPH*SW | Signed per-phase samples, phase p at [p*SW +: SW] |
| ph_en | input | NPH | Per-phase enable |
| cfg_shift | input | 2*3 | Filter shift per path |
| cfg_thr | input | 2*SUMW | Signed threshold per path |
| cfg_dwell | input | 2*CW | Consecutive-sample count per path |
| trip_clr | input | 2 | Clear of each trip flag |
| filt_o | output | 2*SUMW | Filtered total per path |
| trip_o | output | 2 | Latched trip flag per path |
| oc_fault_o | output | 1 | Combined overcurrent fault |

## Verification
The assertions assume that settings and clear bits change only at cycle boundaries. They also assume that samples arrive one strobe at a time, each with a full pipeline of two edges behind it. Under those conditions, a flag can rise only in response to a strobed sample, and a filtered value stays still when no strobe occurred two cycles earlier. The bench follows this pattern: it changes settings only while no sample is in flight, and it holds each strobe for exactly one cycle. The one exception is a clear held across a sample, which is driven on purpose to test the priority rule.

// File: rtl/tocp_pkg.sv
package tocp_pkg;
    localparam int unsigned PATHS   = 2;
    localparam int unsigned SHIFT_W = 3;

    function automatic int unsigned sum_width(input int unsigned nph, input int unsigned sw);
        return sw + $clog2(nph + 1);
    endfunction
endpackage

// File: rtl/tocp_sum.sv
module tocp_sum #(
    parameter int unsigned NPH  = 7,
    parameter int unsigned SW   = 12,
    parameter int unsigned SUMW = 15
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   vld_i,
    input  logic [NPH*SW-1:0]      smp_i,
    input  logic [NPH-1:0]         en_i,
    output logic                   vld_o,
    output logic signed [SUMW-1:0] sum_o
);
    localparam int unsigned EXT = SUMW - SW;

    typedef struct packed {
        logic                   vld;
        logic signed [SUMW-1:0] sum;
    } sum_st_t;

    sum_st_t st_d, st_q;
    logic signed [SUMW-1:0] term [NPH];

    for (genvar p = 0; p < NPH; p++) begin : g_term
        assign term[p] = en_i[p] ? {{EXT{smp_i[p*SW+SW-1]}}, smp_i[p*SW +: SW]} : '0;
    end

    always_comb begin
        st_d = st_q;
        st_d.vld = vld_i;
        if (vld_i) begin
            st_d.sum = '0;
            for (int p = 0; p < NPH; p++) begin
                st_d.sum = st_d.sum + term[p];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o = st_q.vld;
    assign sum_o = st_q.sum;
endmodule

// File: rtl/tocp_path.sv
module tocp_path #(
    parameter int unsigned SUMW = 15,
    parameter int unsigned CW   = 8,
    parameter int unsigned KW   = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   vld_i,
    input  logic signed [SUMW-1:0] sum_i,
    input  logic [KW-1:0]          shift_i,
    input  logic signed [SUMW-1:0] thr_i,
    input  logic [CW-1:0]          dwell_i,
    input  logic                   clr_i,
    output logic signed [SUMW-1:0] filt_o,
    output logic                   trip_o
);
    typedef struct packed {
        logic signed [SUMW-1:0] filt;
        logic [CW-1:0]          cnt;
        logic                   trip;
    } path_st_t;

    path_st_t st_d, st_q;
    logic signed [SUMW:0]   diff, step, wide;
    logic signed [SUMW-1:0] f_new;
    logic [CW-1:0]          need;
    logic                   above, set;

    always_comb begin
        diff  = {sum_i[SUMW-1], sum_i} - {st_q.filt[SUMW-1], st_q.filt};
        step  = diff >>> shift_i;
        wide  = {st_q.filt[SUMW-1], st_q.filt} + step;
        f_new = wide[SUMW-1:0];
        above = f_new > thr_i;
        need  = (dwell_i == '0) ? CW'(1) : dwell_i;
        set   = 1'b0;
        st_d  = st_q;
        if (vld_i) begin
            st_d.filt = f_new;
            if (above) begin
                if (st_q.cnt != '1) st_d.cnt = st_q.cnt + 1'b1;
                set = (st_d.cnt >= need);
            end else begin
                st_d.cnt = '0;
            end
        end
        if (clr_i) st_d.trip = 1'b0;
        if (set)   st_d.trip = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign filt_o = st_q.filt;
    assign trip_o = st_q.trip;
endmodule

// File: rtl/tocp_top.sv
module tocp_top
    import tocp_pkg::*;
#(
    parameter int unsigned NPH  = 7,
    parameter int unsigned SW   = 12,
    parameter int unsigned CW   = 8,
    parameter int unsigned SUMW = sum_width(NPH, SW)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_vld,
    input  logic [NPH*SW-1:0]       smp_i,
    input  logic [NPH-1:0]          ph_en,
    input  logic [PATHS*SHIFT_W-1:0] cfg_shift,
    input  logic [PATHS*SUMW-1:0]   cfg_thr,
    input  logic [PATHS*CW-1:0]     cfg_dwell,
    input  logic [PATHS-1:0]        trip_clr,
    output logic [PATHS*SUMW-1:0]   filt_o,
    output logic [PATHS-1:0]        trip_o,
    output logic                    oc_fault_o
);
    logic                   tot_vld;
    logic signed [SUMW-1:0] tot;

    tocp_sum #(.NPH(NPH), .SW(SW), .SUMW(SUMW)) u_sum (
        .clk(clk), .rst_n(rst_n), .vld_i(smp_vld), .smp_i(smp_i),
        .en_i(ph_en), .vld_o(tot_vld), .sum_o(tot)
    );

    for (genvar g = 0; g < PATHS; g++) begin : g_path
        logic signed [SUMW-1:0] f;
        tocp_path #(.SUMW(SUMW), .CW(CW), .KW(SHIFT_W)) u_path (
            .clk(clk), .rst_n(rst_n), .vld_i(tot_vld), .sum_i(tot),
            .shift_i(cfg_shift[g*SHIFT_W +: SHIFT_W]),
            .thr_i(cfg_thr[g*SUMW +: SUMW]),
            .dwell_i(cfg_dwell[g*CW +: CW]),
            .clr_i(trip_clr[g]),
            .filt_o(f), .trip_o(trip_o[g])
        );
        assign filt_o[g*SUMW +: SUMW] = f;
    end

    assign oc_fault_o = |trip_o;
endmodule

// File: rtl/tocp_checker.sv
module tocp_checker #(
    parameter int unsigned FW = 30
) (
    input logic          clk,
    input logic          rst_n,
    input logic          smp_vld,
    input logic [1:0]    trip_clr,
    input logic [FW-1:0] filt_o,
    input logic [1:0]    trip_o,
    input logic          oc_fault_o
);
    assert_fault_or_R7: assert property (@(posedge clk) disable iff (!rst_n)
        oc_fault_o == (trip_o[0] | trip_o[1]));

    assert_latch0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_o[0] && !trip_clr[0]) |=> trip_o[0]);

    assert_latch1_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_o[1] && !trip_clr[1]) |=> trip_o[1]);

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(smp_vld, 2) |-> $stable(filt_o));

    assert_rise_needs_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trip_o[0]) |-> $past(smp_vld, 2));

    assert_rise1_needs_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trip_o[1]) |-> $past(smp_vld, 2));
endmodule

bind tocp_top tocp_checker #(.FW(2*SUMW)) u_chk (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .trip_clr(trip_clr),
    .filt_o(filt_o), .trip_o(trip_o), .oc_fault_o(oc_fault_o)
);

// File: tb/tocp_top_tb.sv
module tocp_top_tb;
    localparam int NPH = 7, SW = 12, CW = 8, SUMW = 15;

    logic clk = 0, rst_n = 0, smp_vld = 0;
    logic [NPH*SW-1:0] smp_i = '0;
    logic [NPH-1:0]    ph_en = '1;
    logic [5:0]        cfg_shift = '0;
    logic [2*SUMW-1:0] cfg_thr = '0;
    logic [2*CW-1:0]   cfg_dwell = '0;
    logic [1:0]        trip_clr = '0;
    logic [2*SUMW-1:0] filt_o;
    logic [1:0]        trip_o;
    logic              oc_fault_o;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    int ph [NPH];

    always #5 clk = ~clk;

    tocp_top #(.NPH(NPH), .SW(SW), .CW(CW)) u_dut (.*);

    function automatic int filt(input int g);
        return int'($signed(filt_o[g*SUMW +: SUMW]));
    endfunction

    function automatic int ema(input int f, input int x, input int k);
        return f + ((x - f) >>> k);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cfg(input int g, input int k, input int thr, input int dw);
        cfg_shift[g*3 +: 3]    = 3'(k);
        cfg_thr[g*SUMW +: SUMW] = SUMW'(thr);
        cfg_dwell[g*CW +: CW]  = CW'(dw);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0; smp_vld = 0; trip_clr = '0;
        @(negedge clk); rst_n = 1; @(negedge clk);
    endtask

    task automatic set_all(input int v);
        for (int p = 0; p < NPH; p++) ph[p] = v;
    endtask

    // strobe one sample; returns at the negedge after the path update
    task automatic send();
        @(negedge clk);
        for (int p = 0; p < NPH; p++) smp_i[p*SW +: SW] = SW'(ph[p]);
        smp_vld = 1;
        @(negedge clk); smp_vld = 0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R10 filt0", filt(0), 0);
        chk("R10 filt1", filt(1), 0);
        chk("R10 trip", int'(trip_o), 0);
        chk("R10 fault", int'(oc_fault_o), 0);
    endtask

    task automatic t_sum_mask();
        do_reset();
        cfg(0, 0, 16383, 1); cfg(1, 0, 16383, 1);
        ph = '{100, 200, -50, 300, 0, 7, 1000};
        ph_en = '1; send();
        chk("R1 full sum", filt(0), 1557);
        ph = '{2000, 200, -2000, 300, 1500, 7, 1000};
        ph_en = 7'b0101010; send();
        chk("R1 masked sum", filt(0), 507);
        ph_en = '1;
    endtask

    task automatic t_ema();
        int e1, e0;
        do_reset();
        cfg(0, 7, 16383, 1); cfg(1, 2, 16383, 1);
        e0 = 0; e1 = 0;
        set_all(0); ph[0] = 1000;
        for (int i = 0; i < 3; i++) begin
            send(); e0 = ema(e0, 1000, 7); e1 = ema(e1, 1000, 2);
            chk("R2 slow rise", filt(1), e1);
            chk("R2 shift7", filt(0), e0);
        end
        ph[0] = -1000; send(); e1 = ema(e1, -1000, 2);
        chk("R2 negative floor", filt(1), e1);
        chk("R2 negative value", e1, 182);
    endtask

    task automatic t_overflow();
        do_reset();
        cfg(0, 0, 16383, 1); cfg(1, 0, 16383, 1);
        set_all(-2048); send();
        chk("R3 neg full scale", filt(0), -14336);
        set_all(2047); send();
        chk("R3 pos full scale", filt(1), 14329);
    endtask

    task automatic t_dwell();
        do_reset();
        cfg(0, 0, 500, 3); cfg(1, 0, 500, 0);
        set_all(0); ph[2] = 600;
        send();
        chk("R4 dwell0 trips at once", int'(trip_o[1]), 1);
        chk("R4 dwell3 after 1", int'(trip_o[0]), 0);
        send();
        chk("R4 dwell3 after 2", int'(trip_o[0]), 0);
        send();
        chk("R4 dwell3 after 3", int'(trip_o[0]), 1);
    endtask

    task automatic t_clear_count();
        do_reset();
        cfg(0, 0, 500, 3); cfg(1, 0, 16383, 1);
        set_all(0);
        ph[2] = 600; send(); send();
        ph[2] = 500; send();
        ph[2] = 600; send(); send();
        chk("R5 equal resets count", int'(trip_o[0]), 0);
        send();
        chk("R5 trips after fresh run", int'(trip_o[0]), 1);
    endtask

    task automatic t_latch();
        do_reset();
        cfg(0, 0, 500, 1); cfg(1, 0, 16383, 1);
        set_all(0); ph[1] = 800; send();
        ph[1] = 0; send(); send();
        chk("R6 held after drop", int'(trip_o[0]), 1);
        chk("R7 fault with trip0", int'(oc_fault_o), 1);
        @(negedge clk); trip_clr = 2'b10; @(negedge clk); trip_clr = 0;
        chk("R8 other clear ignored", int'(trip_o[0]), 1);
        @(negedge clk); trip_clr = 2'b01; @(negedge clk); trip_clr = 0;
        chk("R6 cleared", int'(trip_o[0]), 0);
        chk("R7 fault clears", int'(oc_fault_o), 0);
        // trip and clear in the same cycle: trip wins
        ph[1] = 800;
        @(negedge clk);
        for (int p = 0; p < NPH; p++) smp_i[p*SW +: SW] = SW'(ph[p]);
        smp_vld = 1; trip_clr = 2'b01;
        @(negedge clk); smp_vld = 0;
        @(negedge clk); trip_clr = 0;
        chk("R6 set beats clear", int'(trip_o[0]), 1);
    endtask

    task automatic t_independent();
        do_reset();
        cfg(0, 0, 100, 1); cfg(1, 3, 10000, 1);
        set_all(0); ph[4] = 1000; send();
        chk("R8 fast trips", int'(trip_o[0]), 1);
        chk("R8 slow holds", int'(trip_o[1]), 0);
        chk("R8 slow own shift", filt(1), 125);
        chk("R7 fault from one path", int'(oc_fault_o), 1);
    endtask

    task automatic t_idle();
        int f0;
        do_reset();
        cfg(0, 0, 300, 1); cfg(1, 0, 16383, 1);
        set_all(0); ph[0] = 200; send();
        f0 = filt(0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            smp_i = {NPH{12'h7FF}}; ph_en = 7'(i * 37);
        end
        @(negedge clk); @(negedge clk);
        ph_en = '1;
        chk("R9 filt unchanged", filt(0), f0);
        chk("R9 no trip", int'(trip_o), 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_sum_mask();
        t_ema();
        t_overflow();
        t_dwell();
        t_clear_count();
        t_latch();
        t_independent();
        t_idle();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule